// File: doc/BRIEF.md
# Host-Settable Device Timestamp Unit

This block keeps a device timestamp that a host can load and read back. A local nanosecond time base runs freely inside the block, advancing by a fixed step every clock. When the host loads a 64-bit time, the unit keeps that value together with a snapshot of the local time base, and it marks the timestamp as valid. When the host asks for the time, the unit answers with the loaded value advanced by the local time that has passed since the load, all modulo 2^64. Until a load has been accepted, every read answers zero.

A load request carries a byte-count field and is accepted only when that count is exactly eight. Every load request gets a one-cycle acknowledge with an error flag and carries no data back. A read answer appears first as a one-cycle 64-bit word and then as eight bytes on a byte stream, least significant byte first. The read path is a small state machine with three states. IDLE waits for a read. REPORT presents the 64-bit word for one cycle. STREAM sends the eight bytes. The transitions are IDLE to REPORT on an accepted read, REPORT to STREAM always, STREAM to STREAM while bytes remain, and STREAM to IDLE after the last byte. A read that arrives while the state machine is not in IDLE is dropped. A load is accepted in any state.

Top module: `ts_host_clock`

## Requirements
- R1: After reset `busy`, `rd_valid`, `ser_valid`, `ser_last` and `set_ack` are all low.
- R2: A read accepted before any load has been accepted returns the value 0.
- R3: A load request with `set_len` equal to 8 stores `set_value`. In the next cycle `set_ack` is high for one cycle with `set_err` low.
- R4: A load request with `set_len` not equal to 8 is rejected. In the next cycle `set_ack` is high with `set_err` high, and the stored time and the valid flag are left unchanged, so later reads return what they would have returned without the request.
- R5: The local time base advances by `NS_PER_CLK` each clock. A read accepted N clocks after an accepted load returns the loaded value plus N*`NS_PER_CLK`.
- R6: `rd_valid` is high for exactly one cycle, the cycle after the read is accepted, and carries the result on `rd_value`.
- R7: Starting the cycle after `rd_valid`, `ser_valid` is high for 8 consecutive cycles. `ser_byte` carries bits [8k+7:8k] of the result in the k-th of those cycles, with k counted from 0, and `ser_last` is high only in the 8th cycle.
- R8: `busy` is high from the cycle after a read is accepted until the last byte is sent. A read request while `busy` is high is dropped and produces no `rd_valid`.
- R9: When a valid load and a read are requested in the same cycle, the load is applied first, and the read returns the loaded value exactly (elapsed time 0).
- R10: The sum of the loaded value and the elapsed time wraps modulo 2^64.
- R11: A load accepted while a result is being streamed does not change the bytes in flight. The next read reflects the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_req | input | 1 | Load request strobe |
| set_len | input | LEN_W (8) | Byte count of the load payload; must be 8 |
| set_value | input | TS_W (64) | Host time to load |
| get_req | input | 1 | Read request strobe |
| set_ack | output | 1 | One-cycle acknowledge of a load request |
| set_err | output | 1 | With set_ack: the load was rejected for its length |
| busy | output | 1 | Read state machine is not idle |
| rd_valid | output | 1 | One-cycle strobe: rd_value holds a read result |
| rd_value | output | TS_W (64) | Read result |
| ser_valid | output | 1 | A result byte is on ser_byte |
| ser_byte | output | 8 | Result byte, least significant first |
| ser_last | output | 1 | Marks the final result byte |

## Verification
A corrupted snapshot or stored host time shows up at the very next read as a result that is wrong by a fixed offset. The bench predicts every result from its own count of clock edges between load and read. A lost or wrongly raised valid flag shows as a zero result where a time was expected, or the reverse, again at the next read. A fault in the state machine or the byte shifter shows within eight cycles of `rd_valid`, as a byte that differs from the scoreboard entry, a misplaced `ser_last`, or an extra `rd_valid` that has no queued expectation.

// File: rtl/ts_pkg.sv
package ts_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_REPORT = 2'd1,
        ST_STREAM = 2'd2
    } resp_state_e;
endpackage

// File: rtl/ts_local_ctr.sv
module ts_local_ctr #(
    parameter int TS_W       = 64,
    parameter int NS_PER_CLK = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] now
);
    localparam logic [TS_W-1:0] STEP = TS_W'(NS_PER_CLK);

    logic [TS_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + STEP;
    end

    assign now = cnt_q;

    // R5: time base moves by one step per clock
    p_ctr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt_q == $past(cnt_q) + STEP));
endmodule

// File: rtl/ts_store.sv
module ts_store #(
    parameter int TS_W  = 64,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_req,
    input  logic [LEN_W-1:0] set_len,
    input  logic [TS_W-1:0]  set_value,
    input  logic [TS_W-1:0]  now,
    output logic             set_ok,
    output logic             time_valid,
    output logic [TS_W-1:0]  host_q,
    output logic [TS_W-1:0]  snap_q,
    output logic             set_ack,
    output logic             set_err
);
    localparam int SET_BYTES = TS_W / 8;
    localparam logic [LEN_W-1:0] LEN_OK = LEN_W'(SET_BYTES);

    assign set_ok = set_req && (set_len == LEN_OK);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_valid <= 1'b0;
            host_q     <= '0;
            snap_q     <= '0;
        end else if (set_ok) begin
            time_valid <= 1'b1;
            host_q     <= set_value;
            snap_q     <= now;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_ack <= 1'b0;
            set_err <= 1'b0;
        end else begin
            set_ack <= set_req;
            set_err <= set_req && !set_ok;
        end
    end

    // R3: an accepted load is held and flagged valid
    p_load_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req && set_len == LEN_OK) |=> (time_valid && host_q == $past(set_value) && set_ack && !set_err));
    // R4: a wrong length leaves the stored time alone
    p_reject_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req && set_len != LEN_OK) |=> ($stable(host_q) && $stable(snap_q) && $stable(time_valid) && set_err));
endmodule

// File: rtl/ts_calc.sv
module ts_calc #(
    parameter int TS_W = 64
) (
    input  logic            time_valid,
    input  logic [TS_W-1:0] host_q,
    input  logic [TS_W-1:0] snap_q,
    input  logic [TS_W-1:0] now,
    input  logic            set_ok,
    input  logic [TS_W-1:0] set_value,
    output logic [TS_W-1:0] result
);
    logic [TS_W-1:0] elapsed;

    always_comb begin
        elapsed = now - snap_q;
        if (set_ok)          result = set_value;
        else if (time_valid) result = host_q + elapsed;
        else                 result = '0;
    end
endmodule

// File: rtl/ts_resp_fsm.sv
module ts_resp_fsm
    import ts_pkg::*;
#(
    parameter int TS_W   = 64,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              get_req,
    input  logic [TS_W-1:0]   result,
    output logic              busy,
    output logic              rd_valid,
    output logic [TS_W-1:0]   rd_value,
    output logic              ser_valid,
    output logic [BYTE_W-1:0] ser_byte,
    output logic              ser_last
);
    localparam int NBYTES = TS_W / BYTE_W;
    localparam int IDX_W  = $clog2(NBYTES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBYTES - 1);

    resp_state_e      state_q, state_d;
    logic [TS_W-1:0]  hold_q, shift_q;
    logic [IDX_W-1:0] idx_q;
    logic             accept;

    assign accept = (state_q == ST_IDLE) && get_req;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (get_req) state_d = ST_REPORT;
            ST_REPORT: state_d = ST_STREAM;
            ST_STREAM: if (idx_q == LAST_IDX) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q  <= '0;
            shift_q <= '0;
            idx_q   <= '0;
        end else if (accept) begin
            hold_q  <= result;
            shift_q <= result;
            idx_q   <= '0;
        end else if (state_q == ST_STREAM) begin
            shift_q <= shift_q >> BYTE_W;
            idx_q   <= idx_q + 1'b1;
        end
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        rd_valid  = (state_q == ST_REPORT);
        rd_value  = hold_q;
        ser_valid = (state_q == ST_STREAM);
        ser_byte  = shift_q[BYTE_W-1:0];
        ser_last  = (state_q == ST_STREAM) && (idx_q == LAST_IDX);
    end

    // R6: result strobe lasts a single cycle
    p_rd_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    // R7: bytes begin right after the result strobe
    p_stream_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> ser_valid);
    // R7: the last-byte marker only with a byte
    p_last_in_stream_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ser_last |-> ser_valid);
    // R8: a read while busy starts nothing
    p_busy_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && get_req) |=> !rd_valid);
endmodule

// File: rtl/ts_host_clock.sv
module ts_host_clock #(
    parameter int TS_W       = 64,
    parameter int LEN_W      = 8,
    parameter int NS_PER_CLK = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_req,
    input  logic [LEN_W-1:0] set_len,
    input  logic [TS_W-1:0]  set_value,
    input  logic             get_req,
    output logic             set_ack,
    output logic             set_err,
    output logic             busy,
    output logic             rd_valid,
    output logic [TS_W-1:0]  rd_value,
    output logic             ser_valid,
    output logic [7:0]       ser_byte,
    output logic             ser_last
);
    logic [TS_W-1:0] now, host_q, snap_q, result;
    logic            set_ok, time_valid;

    ts_local_ctr #(.TS_W(TS_W), .NS_PER_CLK(NS_PER_CLK)) u_ctr (
        .clk(clk), .rst_n(rst_n), .now(now)
    );

    ts_store #(.TS_W(TS_W), .LEN_W(LEN_W)) u_store (
        .clk(clk), .rst_n(rst_n), .set_req(set_req), .set_len(set_len),
        .set_value(set_value), .now(now), .set_ok(set_ok),
        .time_valid(time_valid), .host_q(host_q), .snap_q(snap_q),
        .set_ack(set_ack), .set_err(set_err)
    );

    ts_calc #(.TS_W(TS_W)) u_calc (
        .time_valid(time_valid), .host_q(host_q), .snap_q(snap_q), .now(now),
        .set_ok(set_ok), .set_value(set_value), .result(result)
    );

    ts_resp_fsm #(.TS_W(TS_W), .BYTE_W(8)) u_fsm (
        .clk(clk), .rst_n(rst_n), .get_req(get_req), .result(result),
        .busy(busy), .rd_valid(rd_valid), .rd_value(rd_value),
        .ser_valid(ser_valid), .ser_byte(ser_byte), .ser_last(ser_last)
    );

    // R2: with no load ever taken, a result is zero
    p_zero_unloaded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (get_req && !busy && !time_valid && !set_req) |=> (rd_valid && rd_value == '0));
endmodule

// File: tb/ts_host_clock_tb.sv
module ts_host_clock_tb;
    localparam int NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        set_req = 1'b0;
    logic [7:0]  set_len = '0;
    logic [63:0] set_value = '0;
    logic        get_req = 1'b0;
    logic        set_ack, set_err, busy, rd_valid, ser_valid, ser_last;
    logic [63:0] rd_value;
    logic [7:0]  ser_byte;

    ts_host_clock #(.TS_W(64), .LEN_W(8), .NS_PER_CLK(NS)) u_dut (
        .clk(clk), .rst_n(rst_n), .set_req(set_req), .set_len(set_len),
        .set_value(set_value), .get_req(get_req), .set_ack(set_ack),
        .set_err(set_err), .busy(busy), .rd_valid(rd_valid), .rd_value(rd_value),
        .ser_valid(ser_valid), .ser_byte(ser_byte), .ser_last(ser_last)
    );

    always #5 clk = ~clk;

    int errors = 0;
    int checks = 0;
    int unsigned edges = 0;
    bit done = 1'b0;

    bit          m_flag = 1'b0;
    logic [63:0] m_host = '0;
    int unsigned m_set_edge = 0;

    logic [63:0] exp_q[$];
    logic [63:0] cur_exp = '0;
    int          byte_i = 8;

    always @(posedge clk) if (rst_n) edges++;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: scoreboard pop and byte comparison
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected rd_valid", 64'(rd_value), 64'd0);
            end else begin
                cur_exp = exp_q.pop_front();
                check(rd_value == cur_exp, "R5/R6 rd_value", rd_value, cur_exp);
                byte_i = 0;
            end
        end else if (rst_n && ser_valid) begin
            check(byte_i < 8 && ser_byte == cur_exp[8*(byte_i%8) +: 8], "R7 ser_byte",
                  64'(ser_byte), 64'(cur_exp[8*(byte_i%8) +: 8]));
            check(ser_last == (byte_i == 7), "R7 ser_last", 64'(ser_last), 64'(byte_i == 7));
            byte_i++;
        end
    end

    task automatic push_get(input int unsigned en);
        logic [63:0] e;
        e = m_flag ? (m_host + 64'(en - m_set_edge) * 64'(NS)) : 64'd0;
        exp_q.push_back(e);
    endtask

    task automatic do_get();
        push_get(edges + 1);
        get_req = 1'b1;
        @(negedge clk);
        get_req = 1'b0;
    endtask

    task automatic do_set(input logic [63:0] v, input logic [7:0] len, input string req);
        int unsigned en;
        en = edges + 1;
        set_req = 1'b1; set_len = len; set_value = v;
        @(negedge clk);
        set_req = 1'b0;
        check(set_ack == 1'b1, req, 64'(set_ack), 64'd1);
        check(set_err == (len != 8), req, 64'(set_err), 64'(len != 8));
        if (len == 8) begin m_flag = 1'b1; m_host = v; m_set_edge = en; end
    endtask

    task automatic do_both(input logic [63:0] v);
        m_flag = 1'b1; m_host = v; m_set_edge = edges + 1;
        push_get(edges + 1);
        set_req = 1'b1; set_len = 8'd8; set_value = v; get_req = 1'b1;
        @(negedge clk);
        set_req = 1'b0; get_req = 1'b0;
        check(set_ack && !set_err, "R9 ack", 64'({set_ack, set_err}), 64'h2);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy && !rd_valid && !ser_valid && !ser_last && !set_ack, "R1 reset outputs",
              64'({busy, rd_valid, ser_valid, ser_last, set_ack}), 64'd0);
        // R2 read before any load
        do_get();
        wait_idle();
        // R4 wrong length rejected, still zero
        do_set(64'hDEAD_BEEF_0000_0001, 8'd5, "R4 reject ack");
        do_get();
        wait_idle();
        // R3 + R5 load then read after a gap
        do_set(64'h1122_3344_5566_7788, 8'd8, "R3 load ack");
        repeat (5) @(negedge clk);
        do_get();
        // R8 read while busy is dropped
        get_req = 1'b1;
        check(busy == 1'b1, "R8 busy", 64'(busy), 64'd1);
        @(negedge clk);
        get_req = 1'b0;
        wait_idle();
        // R4 rejected length keeps the old time
        do_set(64'h0, 8'd9, "R4 reject ack 2");
        repeat (2) @(negedge clk);
        do_get();
        wait_idle();
        // R9 load and read in the same cycle
        do_both(64'hA5A5_0F0F_1234_5678);
        wait_idle();
        // R10 wrap modulo 2^64
        do_set(64'hFFFF_FFFF_FFFF_FFF0, 8'd8, "R10 load ack");
        repeat (3) @(negedge clk);
        do_get();
        wait_idle();
        // R11 load during streaming does not disturb bytes
        do_get();
        repeat (2) @(negedge clk);
        do_set(64'h0102_0304_0506_0708, 8'd8, "R11 load ack");
        wait_idle();
        repeat (4) @(negedge clk);
        do_get();
        wait_idle();
        check(exp_q.size() == 0, "R6 all results seen", 64'(exp_q.size()), 64'd0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule